// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for an embedded controller. A 16-bit down-counter is paced by a two-stage prescaler. The first stage picks either a strobe from an external slow clock or a programmable divider of the system clock. The second stage divides again by one of eight powers of two. Software must keep writing a restart key to the block before the counter runs out. If it does not, the block can raise a fixed-length reset pulse, a fixed-length external overflow strobe and a maskable interrupt, and each of these can be enabled on its own.

Writes to the restart, mode and overflow-mode registers carry a key value. Without the correct key, the whole write is thrown away. This keeps runaway code from kicking, retuning or disabling the watchdog by accident. Sticky status flags warn early (the counter's top five bits have run out) and report the overflow itself. Software reaches the block through a one-cycle synchronous write port and a combinational read port.

Top module: `wdog_top`

## Requirements
- R1: A write to address 0 restarts the counter only when wdata[15:0] is 0xC071. A restart loads the counter with {high preload, 11'h7FF} and resets the prescaler. A write with any other value changes nothing.
- R2: A write to address 1 (mode) is taken only when wdata[31:24] is 0x37. When taken, it stores the divide code (bits 2:0), the source select (bit 3), the 11-bit system prescale value (bits 14:4) and the 5-bit high preload (bits 20:16). A read returns these fields in the same positions, with all other bits 0. A write with the wrong key leaves every field unchanged.
- R3: A write to address 2 (overflow mode) is taken only when wdata[15:4] is 0x234. Bit 0 enables counting, bit 1 enables the reset pulse and bit 2 enables the external strobe. A read returns these three bits in bits 2:0.
- R4: The counter steps once for every N base ticks. N is 2, 4, 8, 16, 32, 128, 256 or 1024 for divide codes 0 through 7.
- R5: With source select 1, a base tick occurs once every (prescale value + 1) system clocks. With source select 0, a base tick occurs on each cycle where ext_tick_i is high, so no counting happens while ext_tick_i is low.
- R6: While enabled, the counter decrements by one on each prescaled step and stops at zero. While disabled, it holds its value.
- R7: When a decrement reaches zero, status bit 1 (overflow) is set. reset_o goes high for exactly 8 cycles if the reset pulse is enabled, and ext_o does the same if the external strobe is enabled. Both rise on the edge that zeroes the counter.
- R8: Status bit 0 (pending) is set when a decrement clears the counter's bits 15:11. Status bit 8 reads back live as (enabled and counter bits 15:11 equal zero).
- R9: Writing 1s to address 5 sets interrupt mask bits, and writing 1s to address 6 clears them. Address 7 reads the mask in bits 1:0. irq_o is the OR over bits 1:0 of (status AND mask).
- R10: Writing 1s to address 3 clears the matching sticky status bits (bits 1:0), and address 4 reads the status. A flag event in the same cycle as a clear wins over the clear.
- R11: Address 8 reads the counter in bits 15:0. Bit 16 is high for the one cycle that follows an accepted restart.
- R12: After reset, the counter is 0xFFFF, counting and both pulse enables are off, the high preload is 0x1F, all other mode fields are 0, status and mask are 0, and reset_o, ext_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | One-cycle strobe from the external slow clock |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Masked interrupt request |
| reset_o | output | 1 | Reset pulse on overflow |
| ext_o | output | 1 | External overflow strobe |

## Verification
The assertions check on every cycle the rules that are purely local. A write with a wrong key leaves the mode and overflow-mode registers unchanged. The counter never moves while disabled and stays at zero once it gets there. Prescaled steps are never back to back. A clear-status write removes the overflow flag unless a new overflow arrives in the same cycle. A rising reset pulse only appears with the counter at zero. Only the bench scenarios can show the exact timing: which edge a restart takes effect on, the step period for each source and divide code, the edge on which pending and overflow are flagged, and the 8-cycle pulse width. These depend on whole sequences of register writes and on the count of elapsed cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned HI_W      = 5;
  localparam int unsigned SCAL_W    = 11;
  localparam int unsigned DSEL_W    = 3;
  localparam int unsigned MAX_LOG2  = 10;
  localparam int unsigned PULSE_LEN = 8;

  localparam logic [3:0] A_RESTART = 4'd0;
  localparam logic [3:0] A_MODE    = 4'd1;
  localparam logic [3:0] A_OVF     = 4'd2;
  localparam logic [3:0] A_CLR     = 4'd3;
  localparam logic [3:0] A_STAT    = 4'd4;
  localparam logic [3:0] A_IRQ_SET = 4'd5;
  localparam logic [3:0] A_IRQ_CLR = 4'd6;
  localparam logic [3:0] A_MASK    = 4'd7;
  localparam logic [3:0] A_COUNT   = 4'd8;

  localparam logic [15:0] KICK_KEY = 16'hC071;
  localparam logic [7:0]  MODE_KEY = 8'h37;
  localparam logic [11:0] OVF_KEY  = 12'h234;

  typedef struct packed {
    logic [HI_W-1:0]   hpre;
    logic [SCAL_W-1:0] scal;
    logic              src_sys;
    logic [DSEL_W-1:0] dsel;
  } mode_t;

  localparam mode_t MODE_RST = '{hpre: '1, scal: '0, src_sys: 1'b0, dsel: '0};

  // divide table skips 64
  function automatic int unsigned div_log2(input logic [DSEL_W-1:0] code);
    case (code)
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return int'(code) + 1;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int unsigned SW = SCAL_W,
  parameter int unsigned DW = MAX_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              src_sys_i,
  input  logic [SW-1:0]     scal_i,
  input  logic [DSEL_W-1:0] dsel_i,
  input  logic              ext_tick_i,
  output logic              tick_o
);
  logic [SW-1:0] sys_q;
  logic [DW-1:0] div_q;
  logic [DW-1:0] last;
  logic          base;

  assign last = DW'((32'd1 << div_log2(dsel_i)) - 32'd1);
  assign base = src_sys_i ? (sys_q == scal_i) : ext_tick_i;
  assign tick_o = run_i && !clr_i && base && (div_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= '0;
      div_q <= '0;
    end else if (clr_i || !run_i) begin
      sys_q <= '0;
      div_q <= '0;
    end else begin
      if (src_sys_i) sys_q <= base ? '0 : sys_q + 1'b1;
      if (base)      div_q <= (div_q == last) ? '0 : div_q + 1'b1;
    end
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned HW = HI_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [HW-1:0] hpre_i,
  output logic [CW-1:0] cnt_o,
  output logic          restarting_o,
  output logic          pend_evt_o,
  output logic          ovf_evt_o
);
  localparam int unsigned LW = CW - HW;

  logic [CW-1:0] cnt_q, nxt;
  logic          dec;

  assign dec = !restart_i && en_i && tick_i && (cnt_q != '0);
  assign nxt = cnt_q - 1'b1;
  assign ovf_evt_o  = dec && (nxt == '0);
  assign pend_evt_o = dec && (cnt_q[CW-1:LW] != '0) && (nxt[CW-1:LW] == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '1;
      restarting_o <= 1'b0;
    end else begin
      restarting_o <= restart_i;
      if (restart_i) cnt_q <= {hpre_i, {LW{1'b1}}};
      else if (dec)  cnt_q <= nxt;
    end
  end

  // R6
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> $stable(cnt_q));
  // R6
  stop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !restart_i) |=> cnt_q == '0);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (fire_i)        left_q <= PW'(LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end
  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              restarting_i,
  input  logic              pend_evt_i,
  input  logic              ovf_evt_i,
  output logic              restart_o,
  output mode_t             mode_o,
  output logic [2:0]        ovf_cfg_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned LW = CNT_W - HI_W;

  mode_t      mode_q;
  logic [2:0] ovf_q;
  logic [1:0] st_q, mask_q, st_clr, evt;
  logic       live_pend;
  logic       unused_bits;

  assign unused_bits = ^wdata_i[23:21];
  assign restart_o = wr_i && addr_i == A_RESTART && wdata_i[15:0] == KICK_KEY;
  assign st_clr    = (wr_i && addr_i == A_CLR) ? wdata_i[1:0] : 2'b00;
  assign evt       = {ovf_evt_i, pend_evt_i};
  assign live_pend = ovf_q[0] && (cnt_i[CNT_W-1:LW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      ovf_q  <= '0;
      st_q   <= '0;
      mask_q <= '0;
    end else begin
      if (wr_i && addr_i == A_MODE && wdata_i[31:24] == MODE_KEY)
        mode_q <= '{hpre: wdata_i[20:16], scal: wdata_i[14:4],
                    src_sys: wdata_i[3], dsel: wdata_i[2:0]};
      if (wr_i && addr_i == A_OVF && wdata_i[15:4] == OVF_KEY)
        ovf_q <= wdata_i[2:0];
      st_q <= (st_q & ~st_clr) | evt;
      if (wr_i && addr_i == A_IRQ_SET) mask_q <= mask_q | wdata_i[1:0];
      if (wr_i && addr_i == A_IRQ_CLR) mask_q <= mask_q & ~wdata_i[1:0];
    end
  end

  assign mode_o    = mode_q;
  assign ovf_cfg_o = ovf_q;
  assign irq_o     = |(st_q & mask_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE:  begin
        rdata_o[20:16] = mode_q.hpre;
        rdata_o[14:4]  = mode_q.scal;
        rdata_o[3]     = mode_q.src_sys;
        rdata_o[2:0]   = mode_q.dsel;
      end
      A_OVF:   rdata_o[2:0] = ovf_q;
      A_STAT:  begin
        rdata_o[8]   = live_pend;
        rdata_o[1:0] = st_q;
      end
      A_MASK:  rdata_o[1:0] = mask_q;
      A_COUNT: begin
        rdata_o[16]   = restarting_i;
        rdata_o[15:0] = cnt_i;
      end
      default: rdata_o = '0;
    endcase
  end

  // R2
  mode_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MODE && wdata_i[31:24] != MODE_KEY) |=> $stable(mode_q));
  // R3
  ovf_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_OVF && wdata_i[15:4] != OVF_KEY) |=> $stable(ovf_q));
  // R10
  st_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CLR && wdata_i[1] && !ovf_evt_i) |=> !st_q[1]);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_tick_i,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        reset_o,
  output logic        ext_o
);
  mode_t            mode;
  logic [2:0]       ovf_cfg;
  logic             restart, tick, restarting, pend_evt, ovf_evt;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       pulse;

  wdog_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .restarting_i(restarting),
    .pend_evt_i(pend_evt), .ovf_evt_i(ovf_evt),
    .restart_o(restart), .mode_o(mode), .ovf_cfg_o(ovf_cfg),
    .rdata_o, .irq_o
  );

  wdog_prescale u_pre (
    .clk_i, .rst_ni, .clr_i(restart), .run_i(ovf_cfg[0]),
    .src_sys_i(mode.src_sys), .scal_i(mode.scal), .dsel_i(mode.dsel),
    .ext_tick_i, .tick_o(tick)
  );

  wdog_counter u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(ovf_cfg[0]), .tick_i(tick),
    .hpre_i(mode.hpre), .cnt_o(cnt), .restarting_o(restarting),
    .pend_evt_o(pend_evt), .ovf_evt_o(ovf_evt)
  );

  // index 0: reset pulse, index 1: external strobe
  for (genvar g = 0; g < 2; g++) begin : g_pulse
    wdog_pulse #(.LEN(PULSE_LEN)) u_p (
      .clk_i, .rst_ni, .fire_i(ovf_evt && ovf_cfg[g+1]), .pulse_o(pulse[g])
    );
  end

  assign reset_o = pulse[0];
  assign ext_o   = pulse[1];

  // R7
  rst_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_o) |-> cnt == '0);
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_tick = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_p, ext_p;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  wdog_top u0 (
    .clk_i(clk), .rst_ni, .ext_tick_i(ext_tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .reset_o(rst_p), .ext_o(ext_p)
  );

  // {wr, addr, data, expected read}
  localparam int NV = 23;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'd8, 32'h0,          32'h0000FFFF},  // R12 count
    {1'b0, 4'd1, 32'h0,          32'h001F0000},  // R12 mode
    {1'b0, 4'd2, 32'h0,          32'h00000000},  // R12 ovf
    {1'b0, 4'd4, 32'h0,          32'h00000000},  // R12 status
    {1'b1, 4'd1, 32'h36010005,   32'h0},
    {1'b0, 4'd1, 32'h0,          32'h001F0000},  // R2 bad key
    {1'b1, 4'd1, 32'h37EAF23D,   32'h0},
    {1'b0, 4'd1, 32'h0,          32'h000A723D},  // R2 fields
    {1'b1, 4'd2, 32'h00001237,   32'h0},
    {1'b0, 4'd2, 32'h0,          32'h00000000},  // R3 bad key
    {1'b1, 4'd2, 32'h00002346,   32'h0},
    {1'b0, 4'd2, 32'h0,          32'h00000006},  // R3 accepted
    {1'b1, 4'd5, 32'h00000003,   32'h0},
    {1'b0, 4'd7, 32'h0,          32'h00000003},  // R9 set
    {1'b1, 4'd6, 32'h00000001,   32'h0},
    {1'b0, 4'd7, 32'h0,          32'h00000002},  // R9 clear
    {1'b1, 4'd6, 32'h00000002,   32'h0},
    {1'b0, 4'd7, 32'h0,          32'h00000000},  // R9 clear
    {1'b1, 4'd0, 32'h0000C070,   32'h0},
    {1'b0, 4'd8, 32'h0,          32'h0000FFFF},  // R1 bad key
    {1'b1, 4'd0, 32'hFFFFC071,   32'h0},
    {1'b0, 4'd8, 32'h0,          32'h000157FF},  // R1 R11 restart flag
    {1'b0, 4'd8, 32'h0,          32'h000057FF}   // R11 flag drops
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v1;
    skip(2);
    rst_ni = 1'b1;
    skip(1);
    #1 chk("R12 outputs", {29'b0, irq, rst_p, ext_p}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr = VEC[i][68]; addr = VEC[i][67:64]; wdata = VEC[i][63:32];
      if (!VEC[i][68]) #1 chk($sformatf("vector %0d", i), rdata, VEC[i][31:0]);
    end
    @(negedge clk); wr = 1'b0;

    // R5 R4: system source, prescale 2, divide 2 -> step every 6 clocks
    wr_reg(4'd1, 32'h37000028);
    wr_reg(4'd2, 32'h00002341);
    wr_reg(4'd0, 32'h0000C071);
    rd_chk("R11 flag after restart", 4'd8, 32'h000107FF);
    skip(5); rd_chk("R5 before step", 4'd8, 32'h000007FF);
    skip(1); rd_chk("R5 first step", 4'd8, 32'h000007FE);
    rd_chk("R8 live pending", 4'd4, 32'h00000100);
    wr_reg(4'd2, 32'h00002340);
    addr = 4'd8; #1 v1 = rdata;
    skip(20); rd_chk("R6 hold when disabled", 4'd8, v1);

    // R4: external source held high, code 5 -> divide 128
    ext_tick = 1'b1;
    wr_reg(4'd1, 32'h37000005);
    wr_reg(4'd2, 32'h00002341);
    wr_reg(4'd0, 32'h0000C071);
    skip(127); rd_chk("R4 before 128", 4'd8, 32'h000007FF);
    skip(1);   rd_chk("R4 step at 128", 4'd8, 32'h000007FE);
    ext_tick = 1'b0;
    addr = 4'd8; #1 v1 = rdata;
    skip(300); rd_chk("R5 no ext tick no step", 4'd8, v1);

    // R7: overflow with both pulses enabled and overflow irq unmasked
    wr_reg(4'd1, 32'h37000008);
    wr_reg(4'd5, 32'h00000002);
    wr_reg(4'd3, 32'h00000003);
    wr_reg(4'd2, 32'h00002347);
    wr_reg(4'd0, 32'h0000C071);
    skip(4092); rd_chk("R6 count near end", 4'd8, 32'h00000001);
    skip(1); chk("R7 no pulse yet", {30'b0, rst_p, ext_p}, 32'h0);
    skip(1); rd_chk("R7 zero", 4'd8, 32'h00000000);
    chk("R7 pulses rise", {29'b0, irq, rst_p, ext_p}, 32'h7);
    rd_chk("R7 status ovf", 4'd4, 32'h00000102);
    skip(7); chk("R7 pulse at 8th cycle", {30'b0, rst_p, ext_p}, 32'h3);
    skip(1); chk("R7 pulse ended", {30'b0, rst_p, ext_p}, 32'h0);
    rd_chk("R6 stays zero", 4'd8, 32'h00000000);
    wr_reg(4'd3, 32'h00000002);
    rd_chk("R10 ovf cleared", 4'd4, 32'h00000100);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);

    // R8: high preload 1 -> early warning after 2048 steps
    wr_reg(4'd1, 32'h37010008);
    wr_reg(4'd6, 32'h00000003);
    wr_reg(4'd5, 32'h00000001);
    wr_reg(4'd0, 32'h0000C071);
    skip(4095); rd_chk("R8 before pending", 4'd4, 32'h00000000);
    chk("R9 no irq", {31'b0, irq}, 32'h0);
    skip(1); rd_chk("R8 pending set", 4'd4, 32'h00000101);
    rd_chk("R8 count", 4'd8, 32'h000007FF);
    chk("R9 pending irq", {31'b0, irq}, 32'h1);

    summary();
  end
endmodule